// File: doc/BRIEF.md
# Sixteen-bit ALU with flags

This block is a stateless arithmetic logic unit for a simple datapath. Two 16-bit operands and a 4-bit operation code enter, and one 16-bit result and three flags leave in the same cycle. It has no clock, no reset and no storage. Callers that want a registered result place their own flops around it.

The scalar operations are add, subtract, three shifts, a signed less-than compare, OR and AND. Four further codes treat each operand as two independent 8-bit lanes and apply multiply, divide, add or subtract to each lane. The three flags are unsigned overflow, signed overflow and operand equality. The equality flag does not depend on the operation code.

Top module: `alu16_core`

## Requirements
- R1: Code 0x0 gives the sum op_a + op_b modulo 2^16. Code 0x1 gives op_a - op_b modulo 2^16.
- R2: Code 0x2 shifts op_a left and fills with zeros. Code 0x3 shifts it right and fills with zeros. Code 0x4 shifts it right and fills with copies of op_a[15]. The shift amount is op_b[3:0] only, and op_b[15:4] has no effect.
- R3: Code 0x5 compares the operands as two's complement numbers. result[0] is 1 when op_a is less than op_b and 0 otherwise, and result[15:1] is zero.
- R4: Code 0x6 gives the bitwise OR of the operands and code 0x7 gives their bitwise AND.
- R5: equal is 1 exactly when op_a and op_b are bit-identical, under all 16 operation codes.
- R6: ovf_u is 1 only under code 0x0, and only when the addition carries out of bit 15.
- R7: ovf_s is 1 only under codes 0x0 and 0x1, and only on two's complement overflow. For add, the operands have the same sign and the result sign differs. For subtract, the operands differ in sign and the result sign differs from op_a.
- R8: Codes 0x8, 0x9, 0xA and 0xB work on lanes [15:8] and [7:0] independently, with no carry or borrow between lanes. Code 0x8 gives the low 8 bits of each lane product. Code 0x9 gives each unsigned lane quotient, or 0xFF in a lane whose divisor is zero. Code 0xA gives each lane sum modulo 256, and code 0xB gives each lane difference modulo 256.
- R9: Codes 0xC to 0xF drive result to zero. Under every code other than 0x0 and 0x1, both overflow flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand; bits [3:0] give the shift amount |
| op_sel | input | 4 | Operation code |
| result | output | 16 | Result of the selected operation |
| ovf_u | output | 1 | Unsigned overflow of an add |
| ovf_s | output | 1 | Signed overflow of an add or subtract |
| equal | output | 1 | Operands are bit-identical |

## Verification
The equality flag is produced beside every operation, so it can be raised in the same cycle as an overflow flag or a nonzero result. The bench provokes this by holding both operands at 0x8000 and stepping through all sixteen operation codes. For the add, a zero result then appears together with both overflow flags and with equal high. Under each code, all four outputs are compared against a model built from the requirements, so a flag that is dropped or leaks into another code shows as a mismatch.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
   localparam logic [3:0] OP_ADD  = 4'h0;
   localparam logic [3:0] OP_SUB  = 4'h1;
   localparam logic [3:0] OP_SLL  = 4'h2;
   localparam logic [3:0] OP_SRL  = 4'h3;
   localparam logic [3:0] OP_SRA  = 4'h4;
   localparam logic [3:0] OP_SLT  = 4'h5;
   localparam logic [3:0] OP_OR   = 4'h6;
   localparam logic [3:0] OP_AND  = 4'h7;
   localparam logic [3:0] OP_PMUL = 4'h8;
   localparam logic [3:0] OP_PDIV = 4'h9;
   localparam logic [3:0] OP_PADD = 4'hA;
   localparam logic [3:0] OP_PSUB = 4'hB;

   localparam logic [1:0] SH_LEFT  = 2'd0;
   localparam logic [1:0] SH_RLOG  = 2'd1;
   localparam logic [1:0] SH_RARI  = 2'd2;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         carry,
   output logic         sovf
);
   logic [W-1:0] b_eff;
   logic [W:0]   full;

   assign b_eff = sub ? ~b : b;
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
   assign sum   = full[W-1:0];
   assign carry = full[W];
   // same effective sign in, different sign out
   assign sovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
   parameter int W  = 16,
   parameter int SH = $clog2(W)
) (
   input  logic [W-1:0]  a,
   input  logic [SH-1:0] amt,
   input  logic [1:0]    mode,
   output logic [W-1:0]  y
);
   import alu16_pkg::*;

   logic [W-1:0] stage [0:SH];
   logic [W-1:0] a_rev;
   logic [W-1:0] out_rev;
   logic         fill;
   logic         left;

   assign left = (mode == SH_LEFT);
   assign fill = (mode == SH_RARI) & a[W-1];

   // a left shift runs through the right-shift ladder on reversed bits
   for (genvar i = 0; i < W; i++) begin : g_rev
      assign a_rev[i]   = a[W-1-i];
      assign out_rev[i] = stage[SH][W-1-i];
   end

   assign stage[0] = left ? a_rev : a;

   for (genvar k = 0; k < SH; k++) begin : g_stage
      localparam int D = 1 << k;
      assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
   end

   assign y = left ? out_rev : stage[SH];
endmodule

// File: rtl/alu16_simd.sv
module alu16_simd #(
   parameter int W  = 16,
   parameter int LW = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   op,
   output logic [W-1:0] y
);
   localparam int NL = W / LW;

   for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [LW-1:0]   la, lb, quo, res;
      logic [2*LW-1:0] prod;

      assign la   = a[i*LW +: LW];
      assign lb   = b[i*LW +: LW];
      assign prod = {{LW{1'b0}}, la} * {{LW{1'b0}}, lb};
      assign quo  = (lb == '0) ? '1 : la / lb;

      always_comb begin
         case (op)
            2'd0:    res = prod[LW-1:0];
            2'd1:    res = quo;
            2'd2:    res = la + lb;
            default: res = la - lb;
         endcase
      end

      assign y[i*LW +: LW] = res;
   end
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
   parameter int WIDTH  = 16,
   parameter int LANE_W = 8
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [3:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             ovf_u,
   output logic             ovf_s,
   output logic             equal
);
   import alu16_pkg::*;

   localparam int SH = $clog2(WIDTH);

   if ((1 << SH) != WIDTH) begin : g_bad_width
      $error("alu16_core: WIDTH must be a power of two");
   end
   if ((WIDTH % LANE_W) != 0 || LANE_W < 2) begin : g_bad_lane
      $error("alu16_core: LANE_W must divide WIDTH");
   end

   logic [WIDTH-1:0] as_sum, sh_y, simd_y;
   logic             as_carry, as_sovf, lt;
   logic [1:0]       sh_mode;

   alu16_addsub #(.W(WIDTH)) u_addsub (
      .a(op_a), .b(op_b), .sub(op_sel != OP_ADD),
      .sum(as_sum), .carry(as_carry), .sovf(as_sovf)
   );

   always_comb begin
      case (op_sel)
         OP_SRL:  sh_mode = SH_RLOG;
         OP_SRA:  sh_mode = SH_RARI;
         default: sh_mode = SH_LEFT;
      endcase
   end

   alu16_shift #(.W(WIDTH), .SH(SH)) u_shift (
      .a(op_a), .amt(op_b[SH-1:0]), .mode(sh_mode), .y(sh_y)
   );

   alu16_simd #(.W(WIDTH), .LW(LANE_W)) u_simd (
      .a(op_a), .b(op_b), .op(op_sel[1:0]), .y(simd_y)
   );

   // signed less-than from the subtract path
   assign lt = as_sum[WIDTH-1] ^ as_sovf;

   always_comb begin
      case (op_sel)
         OP_ADD, OP_SUB:           result = as_sum;
         OP_SLL, OP_SRL, OP_SRA:   result = sh_y;
         OP_SLT:                   result = {{(WIDTH-1){1'b0}}, lt};
         OP_OR:                    result = op_a | op_b;
         OP_AND:                   result = op_a & op_b;
         OP_PMUL, OP_PDIV,
         OP_PADD, OP_PSUB:         result = simd_y;
         default:                  result = '0;
      endcase
   end

   assign ovf_u = (op_sel == OP_ADD) & as_carry;
   assign ovf_s = ((op_sel == OP_ADD) | (op_sel == OP_SUB)) & as_sovf;
   assign equal = (op_a == op_b);
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
   parameter int W = 16
) (
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic [3:0]   op_sel,
   input logic [W-1:0] result,
   input logic         ovf_u,
   input logic         ovf_s,
   input logic         equal
);
   import alu16_pkg::*;

   always_comb begin
      // R1: an add without carry out never wraps below op_a
      a_r1_add_nowrap: assert (!(op_sel == OP_ADD && !ovf_u) || result >= op_a);
      // R2: zero shift amount passes op_a through
      a_r2_zero_shift: assert (!((op_sel == OP_SLL || op_sel == OP_SRL || op_sel == OP_SRA)
                                  && op_b[3:0] == 4'd0) || result == op_a);
      // R3: compare result is a single bit
      a_r3_slt_bit: assert (op_sel != OP_SLT || result[W-1:1] == '0);
      // R5: equal operands subtract to zero
      a_r5_eq_sub: assert (!(op_sel == OP_SUB && equal) || result == '0);
      // R6: unsigned overflow only on add
      a_r6_uovf_add_only: assert (!ovf_u || op_sel == OP_ADD);
      // R7: signed overflow only on add or subtract
      a_r7_sovf_scope: assert (!ovf_s || op_sel == OP_ADD || op_sel == OP_SUB);
      // R9: unused codes give a zero result and no flags
      a_r9_no_overflow: assert (op_sel < 4'hC || (result == '0 && !ovf_u && !ovf_s));
   end
endmodule

bind alu16_core alu16_chk #(.W(WIDTH)) u_chk (
   .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result),
   .ovf_u(ovf_u), .ovf_s(ovf_s), .equal(equal)
);

// File: tb/sim_alu16_core.sv
module sim_alu16_core;
   typedef struct {
      logic [15:0] res;
      logic        u;
      logic        s;
      logic        eq;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic [3:0]  op_sel = '0;
   logic [15:0] result;
   logic        ovf_u, ovf_s, equal;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #2 clk = ~clk;

   alu16_core u0 (
      .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .result(result), .ovf_u(ovf_u), .ovf_s(ovf_s), .equal(equal)
   );

   function automatic exp_t model(input logic [15:0] a, input logic [15:0] b,
                                  input logic [3:0] s, input string tag);
      exp_t e;
      int sa, sb, sr;
      logic [16:0] wide;
      sa = int'($signed(a));
      sb = int'($signed(b));
      e.res = '0; e.u = 1'b0; e.s = 1'b0; e.eq = (a == b); e.tag = tag;
      case (s)
         4'h0: begin
            wide = {1'b0, a} + {1'b0, b};
            e.res = wide[15:0]; e.u = wide[16];
            sr = sa + sb; e.s = (sr > 32767 || sr < -32768);
         end
         4'h1: begin
            e.res = a - b;
            sr = sa - sb; e.s = (sr > 32767 || sr < -32768);
         end
         4'h2: e.res = a << b[3:0];
         4'h3: e.res = a >> b[3:0];
         4'h4: e.res = 16'($signed(a) >>> b[3:0]);
         4'h5: e.res = (sa < sb) ? 16'd1 : 16'd0;
         4'h6: e.res = a | b;
         4'h7: e.res = a & b;
         4'h8, 4'h9, 4'hA, 4'hB: begin
            for (int l = 0; l < 2; l++) begin
               logic [7:0] x, y, r;
               logic [15:0] p;
               x = a[l*8 +: 8]; y = b[l*8 +: 8];
               p = x * y;
               case (s)
                  4'h8: r = p[7:0];
                  4'h9: r = (y == 0) ? 8'hFF : x / y;
                  4'hA: r = x + y;
                  default: r = x - y;
               endcase
               e.res[l*8 +: 8] = r;
            end
         end
         default: e.res = '0;
      endcase
      return e;
   endfunction

   task automatic drive(input logic [15:0] a, input logic [15:0] b,
                        input logic [3:0] s, input string tag);
      @(posedge clk);
      op_a = a; op_b = b; op_sel = s;
      q.push_back(model(a, b, s, tag));
   endtask

   // monitor: results of the current inputs are settled by the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (result !== e.res || ovf_u !== e.u || ovf_s !== e.s || equal !== e.eq) begin
            failures++;
            $display("FAIL %s sel=%h a=%h b=%h: res=%h u=%b s=%b eq=%b expected res=%h u=%b s=%b eq=%b",
                     e.tag, op_sel, op_a, op_b, result, ovf_u, ovf_s, equal,
                     e.res, e.u, e.s, e.eq);
         end
      end
   end

   function automatic string tag_of(input logic [3:0] s);
      case (s)
         4'h0, 4'h1: return "R1/R6/R7";
         4'h2, 4'h3, 4'h4: return "R2";
         4'h5: return "R3";
         4'h6, 4'h7: return "R4";
         4'h8, 4'h9, 4'hA, 4'hB: return "R8";
         default: return "R9";
      endcase
   endfunction

   initial begin
      logic [15:0] lf;
      // idle inputs: all zero under add
      q.push_back(model(16'h0, 16'h0, 4'h0, "R5 idle"));
      @(posedge clk);
      drive(16'h1234, 16'h0F0F, 4'h0, "R1 add");
      drive(16'h0005, 16'h0007, 4'h1, "R1 sub");
      drive(16'hFFFF, 16'h0001, 4'h0, "R6 carry out");
      drive(16'h0000, 16'h0001, 4'h1, "R6 sub no uovf");
      drive(16'h7FFF, 16'h0001, 4'h0, "R7 add pos");
      drive(16'h8000, 16'h8000, 4'h0, "R7 add neg");
      drive(16'h8000, 16'h0001, 4'h1, "R7 sub neg-pos");
      drive(16'h7FFF, 16'hFFFF, 4'h1, "R7 sub pos-neg");
      drive(16'h8001, 16'h0011, 4'h2, "R2 sll high bits ignored");
      drive(16'h8000, 16'h000F, 4'h3, "R2 srl 15");
      drive(16'h8000, 16'hFFF4, 4'h4, "R2 sra fill");
      drive(16'h4000, 16'h0003, 4'h4, "R2 sra positive");
      drive(16'hFFFF, 16'h0001, 4'h5, "R3 neg lt pos");
      drive(16'h0001, 16'hFFFF, 4'h5, "R3 pos not lt neg");
      drive(16'h1234, 16'h1234, 4'h5, "R3 equal");
      drive(16'hF0A0, 16'h0F05, 4'h6, "R4 or");
      drive(16'hF0A5, 16'h3C0F, 4'h7, "R4 and");
      drive(16'h1003, 16'h2005, 4'h8, "R8 pmul");
      drive(16'h6407, 16'h0A00, 4'h9, "R8 pdiv by zero lane");
      drive(16'hFF01, 16'h0101, 4'hA, "R8 padd no lane carry");
      drive(16'h0100, 16'h0001, 4'hB, "R8 psub no lane borrow");
      for (int s = 12; s < 16; s++) drive(16'hFFFF, 16'h7FFF, 4'(s), "R9 unused");
      // overlap: equal operands under every code
      for (int s = 0; s < 16; s++) drive(16'h8000, 16'h8000, 4'(s), "R5 eq overlap");
      lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         logic [15:0] ra, rb;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         ra = lf;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         rb = (n % 7 == 0) ? ra : lf;
         drive(ra, rb, 4'(n % 16), tag_of(4'(n % 16)));
      end
      wait (q.size() == 0);
      @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired: actual hung, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule